// File: doc/BRIEF.md
# Data Address Watchpoint Unit

This block observes every data access a processor core issues and raises a debug request when an access falls inside one of two programmed address regions. Each of the two channels, numbered 0 and 1, holds a base address and a control word. The control word carries a six-bit compare mask and two enables, one for loads and one for stores. The mask sets the region size to a power of two between 1 and 64 bytes. A mask bit that is clear removes the matching low address bit from the compare, so the watched region is always the naturally aligned block that contains the base.

When an enabled channel matches a valid access, the unit raises `dbg_req` for one cycle, in the cycle after the access was sampled. In the same step it latches a cause word that marks a data break and records which channel fired. The cause word stays as it is, and later matches are dropped, until software clears it. The channel registers and the cause clear are written through a single write port. A control write that sets reserved bits is refused and flagged.

A small state machine sequences the report. In ARMED the unit watches for hits. The transition ARMED→SIGNAL happens on a hit. SIGNAL→PENDING always follows after one cycle. PENDING→ARMED happens on a cause clear, and SIGNAL→ARMED also happens on a cause clear. ARMED is left only by a hit.

Top module: `dwatch_unit`

## Requirements
- R1: Writes with `cfg_we` high select the target with `cfg_addr`: 3'b000 base of channel 0, 3'b001 control of channel 0, 3'b010 base of channel 1, 3'b011 control of channel 1, and any value with bit 2 set clears the cause word.
- R2: A channel matches a valid access (`mem_vld` high) when address bits 31..6 equal the base, and each address bit i in 0..5 whose control mask bit i is set equals base bit i. Address bits whose mask bit is clear are ignored. An access with `mem_vld` low never matches.
- R3: Control bit 30 enables matching on loads (`mem_store` low) and control bit 31 enables matching on stores (`mem_store` high). With both bits set, any access can match.
- R4: After reset both control words are zero. A channel whose control bits 30 and 31 are both clear never triggers.
- R5: A control write with any of bits 29..6 set is discarded, leaving the old control word in place, and `cfg_err` is high for the one cycle after that write. Accepted writes leave `cfg_err` low.
- R6: On a hit sampled at a clock edge while the unit is armed, `dbg_req` is high for exactly the following cycle and then returns low.
- R7: On a hit the cause word gets bit 2 set (data break). Bit 8 is set when channel 1 fired and clear when channel 0 fired. All other bits read zero.
- R8: If both channels match the same access, channel 0 is reported, so bit 8 of the cause word is clear.
- R9: The cause word holds its value until a cause-clear write. While it is nonzero, further hits raise no `dbg_req` and do not change it. After the clear, the next hit is reported again.
- R10: During and just after reset, `dbg_req`, `cfg_err` and the cause word are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Write target select |
| cfg_wdata | input | 32 | Write data |
| cfg_err | output | 1 | Rejected control write, one cycle after the write |
| mem_vld | input | 1 | Data access valid |
| mem_addr | input | 32 | Data access byte address |
| mem_store | input | 1 | 1 = store, 0 = load |
| dbg_req | output | 1 | One-cycle debug request |
| cause | output | 16 | Latched break cause |

## Verification
The hardest situation to reach is a second matching access that arrives while an earlier cause is still pending. Reaching it means keeping the unit in PENDING on purpose and then driving a hit. The bench does this in a directed step: it raises a report, skips the clear, applies a fresh matching access, checks that nothing changes, and only then clears and re-triggers. Equal-priority hits are set up by moving channel 1's base on top of channel 0's region. The misaligned-base case is covered by programming channel 0 with a base that is not aligned to its 32-byte region size, then probing both edges of the aligned block.

// File: rtl/dwu_pkg.sv
package dwu_pkg;
    localparam int DATA_W   = 32;
    localparam int MASK_W   = 6;
    localparam int NUM_CH   = 2;
    localparam int CAUSE_W  = 16;
    localparam int LD_BIT   = 30;
    localparam int ST_BIT   = 31;
    localparam int DBRK_BIT = 2;
    localparam int CH1_BIT  = 8;

    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,
        ST_SIGNAL  = 2'd1,
        ST_PENDING = 2'd2
    } wp_state_e;
endpackage

// File: rtl/dwu_channel.sv
module dwu_channel #(
    parameter int ADDR_W = 32,
    parameter int MASK_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_base,
    input  logic              wr_ctrl,
    input  logic [ADDR_W-1:0] wdata,
    input  logic [MASK_W-1:0] new_mask,
    input  logic              new_ld,
    input  logic              new_st,
    input  logic              acc_vld,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_store,
    output logic              hit
);
    localparam int HI_W = ADDR_W - MASK_W;

    logic [ADDR_W-1:0] base_q;
    logic [MASK_W-1:0] mask_q;
    logic              ld_q;
    logic              st_q;
    logic [ADDR_W-1:0] cmp_mask;
    logic              kind_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
            ld_q   <= 1'b0;
            st_q   <= 1'b0;
        end else begin
            if (wr_base) base_q <= wdata;
            if (wr_ctrl) begin
                mask_q <= new_mask;
                ld_q   <= new_ld;
                st_q   <= new_st;
            end
        end
    end

    always_comb begin
        cmp_mask = {{HI_W{1'b1}}, mask_q};
        kind_ok  = acc_store ? st_q : ld_q;
        hit      = acc_vld && kind_ok && (((acc_addr ^ base_q) & cmp_mask) == '0);
    end
endmodule

// File: rtl/dwu_fsm.sv
module dwu_fsm
    import dwu_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCH-1:0]     hit,
    input  logic               clr,
    output logic               dbg_req,
    output logic [CAUSE_W-1:0] cause
);
    wp_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED:   if (|hit) state_d = ST_SIGNAL;
            ST_SIGNAL:  state_d = clr ? ST_ARMED : ST_PENDING;
            ST_PENDING: if (clr) state_d = ST_ARMED;
            default:    state_d = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause <= '0;
        end else if (state_q == ST_ARMED && (|hit)) begin
            cause           <= '0;
            cause[DBRK_BIT] <= 1'b1;
            cause[CH1_BIT]  <= ~hit[0];
        end else if (clr) begin
            cause <= '0;
        end
    end

    always_comb begin
        dbg_req = (state_q == ST_SIGNAL);
    end
endmodule

// File: rtl/dwatch_unit.sv
module dwatch_unit
    import dwu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_addr,
    input  logic [DATA_W-1:0]  cfg_wdata,
    output logic               cfg_err,
    input  logic               mem_vld,
    input  logic [DATA_W-1:0]  mem_addr,
    input  logic               mem_store,
    output logic               dbg_req,
    output logic [CAUSE_W-1:0] cause
);
    logic [NUM_CH-1:0] hit;
    logic              ctrl_sel;
    logic              ctrl_bad;
    logic              clr;

    always_comb begin
        ctrl_sel = cfg_we && !cfg_addr[2] && cfg_addr[0];
        ctrl_bad = |cfg_wdata[LD_BIT-1:MASK_W];
        clr      = cfg_we && cfg_addr[2];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err <= 1'b0;
        else        cfg_err <= ctrl_sel && ctrl_bad;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel;
        assign sel = cfg_we && !cfg_addr[2] && (cfg_addr[1] == c[0]);
        dwu_channel #(
            .ADDR_W (DATA_W),
            .MASK_W (MASK_W)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_base   (sel && !cfg_addr[0]),
            .wr_ctrl   (sel && cfg_addr[0] && !ctrl_bad),
            .wdata     (cfg_wdata),
            .new_mask  (cfg_wdata[MASK_W-1:0]),
            .new_ld    (cfg_wdata[LD_BIT]),
            .new_st    (cfg_wdata[ST_BIT]),
            .acc_vld   (mem_vld),
            .acc_addr  (mem_addr),
            .acc_store (mem_store),
            .hit       (hit[c])
        );
    end

    dwu_fsm #(
        .NCH (NUM_CH)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .clr     (clr),
        .dbg_req (dbg_req),
        .cause   (cause)
    );
endmodule

// File: rtl/dwu_checker.sv
module dwu_checker
    import dwu_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_we,
    input logic [2:0]         cfg_addr,
    input logic               cfg_err,
    input logic               dbg_req,
    input logic [CAUSE_W-1:0] cause
);
    a_r6_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req |=> !dbg_req);

    a_r7_req_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req |-> cause[DBRK_BIT]);

    a_r7_ch_bit_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        cause[CH1_BIT] |-> cause[DBRK_BIT]);

    a_r9_cause_rise_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cause[DBRK_BIT]) |-> dbg_req);

    a_r9_cause_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cause[DBRK_BIT] && !(cfg_we && cfg_addr[2])) |=> $stable(cause));

    a_r5_err_after_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(cfg_we && !cfg_addr[2] && cfg_addr[0]));
endmodule

bind dwatch_unit dwu_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_err  (cfg_err),
    .dbg_req  (dbg_req),
    .cause    (cause)
);

// File: tb/dwatch_unit_bench.sv
`timescale 1ns/1ps
module dwatch_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_err;
    logic        mem_vld = 1'b0;
    logic [31:0] mem_addr = '0;
    logic        mem_store = 1'b0;
    logic        dbg_req;
    logic [15:0] cause;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dwatch_unit u_dwatch_unit (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_err(cfg_err), .mem_vld(mem_vld),
        .mem_addr(mem_addr), .mem_store(mem_store), .dbg_req(dbg_req),
        .cause(cause)
    );

    // {addr[31:0], store, expect_hit, expect_channel}
    localparam logic [34:0] VEC [8] = '{
        {32'h1000_0020, 1'b0, 1'b1, 1'b0},
        {32'h1000_003F, 1'b1, 1'b1, 1'b0},
        {32'h1000_0040, 1'b0, 1'b0, 1'b0},
        {32'h1000_001F, 1'b1, 1'b0, 1'b0},
        {32'h2000_0005, 1'b1, 1'b1, 1'b1},
        {32'h2000_0005, 1'b0, 1'b0, 1'b0},
        {32'h2000_0004, 1'b1, 1'b0, 1'b0},
        {32'h3000_0020, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // drives one access; returns at the negedge after the sampling edge
    task automatic access(input logic [31:0] a, input logic st, input logic vld);
        @(negedge clk);
        mem_vld = vld; mem_addr = a; mem_store = st;
        @(negedge clk);
        mem_vld = 1'b0;
    endtask

    function automatic logic [31:0] exp_cause(input logic h, input logic ch);
        return h ? (32'h4 | (ch ? 32'h100 : 32'h0)) : 32'h0;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset values
        check("R10 dbg_req", {31'b0, dbg_req}, 32'h0);
        check("R10 cause", {16'b0, cause}, 32'h0);
        check("R10 cfg_err", {31'b0, cfg_err}, 32'h0);
        rst_n = 1'b1;

        // R4: reset control is zero, so nothing triggers
        access(32'h0000_0000, 1'b1, 1'b1);
        check("R4 no trigger after reset", {31'b0, dbg_req}, 32'h0);

        // R1 programming: ch0 misaligned base, 32 bytes, any access; ch1 1 byte, store only
        wr(3'b000, 32'h1000_0023);
        check("R5 valid write no error", {31'b0, cfg_err}, 32'h0);
        wr(3'b001, 32'hC000_0020);
        wr(3'b010, 32'h2000_0005);
        wr(3'b011, 32'h8000_003F);

        // vector table: R2 R3 R6 R7
        foreach (VEC[i]) begin
            access(VEC[i][34:3], VEC[i][2], 1'b1);
            check("R6/R2/R3 dbg_req", {31'b0, dbg_req}, {31'b0, VEC[i][1]});
            check("R7 cause", {16'b0, cause}, exp_cause(VEC[i][1], VEC[i][0]));
            @(negedge clk);
            check("R6 req drops", {31'b0, dbg_req}, 32'h0);
            wr(3'b100, 32'h0);
            check("R9 cleared", {16'b0, cause}, 32'h0);
        end

        // R2: mem_vld low never matches
        access(32'h1000_0020, 1'b0, 1'b0);
        check("R2 invalid access ignored", {31'b0, dbg_req}, 32'h0);

        // R5: reserved bits rejected, old control kept
        wr(3'b001, 32'h0000_1000);
        check("R5 cfg_err pulse", {31'b0, cfg_err}, 32'h1);
        @(negedge clk);
        check("R5 cfg_err one cycle", {31'b0, cfg_err}, 32'h0);
        access(32'h1000_0030, 1'b0, 1'b1);
        check("R5 old ctrl kept", {16'b0, cause}, 32'h4);
        wr(3'b100, 32'h0);

        // R8: both channels hit, channel 0 reported
        wr(3'b010, 32'h1000_0030);
        wr(3'b011, 32'hC000_003F);
        access(32'h1000_0030, 1'b1, 1'b1);
        check("R8 priority ch0", {16'b0, cause}, 32'h4);
        wr(3'b100, 32'h0);

        // R4: clear ch0 control, ch1 alone fires
        wr(3'b001, 32'h0);
        access(32'h1000_0030, 1'b1, 1'b1);
        check("R4/R7 ch1 report", {16'b0, cause}, 32'h104);

        // R9: pending cause blocks further hits
        @(negedge clk);
        access(32'h1000_0030, 1'b0, 1'b1);
        check("R9 no req while pending", {31'b0, dbg_req}, 32'h0);
        check("R9 cause held", {16'b0, cause}, 32'h104);
        wr(3'b100, 32'h0);
        check("R9 clear", {16'b0, cause}, 32'h0);
        access(32'h1000_0030, 1'b0, 1'b1);
        check("R9 rearmed", {31'b0, dbg_req}, 32'h1);
        wr(3'b100, 32'h0);

        // R4: both channels disabled
        wr(3'b011, 32'h0);
        access(32'h1000_0030, 1'b1, 1'b1);
        check("R4 disabled channels", {31'b0, dbg_req}, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule